// File: doc/BRIEF.md
# Boot Vector and Overlay Controller

This block sits between an 8-bit processor core and its program memory. When reset is released it reads three inputs: a stored boot status value, a stored boot vector byte and a hardware force-boot pin. From these it works out where execution begins and holds that start address in a register for the core. It also reports whether the core entered through the vector, so that bootloader code can test it.

After reset a 1 kB boot region sits over the top of the 64 kB code space. While that overlay is enabled, fetches that fall in the window go to boot memory. All other fetches go to user flash. Software turns the overlay off with a single write strobe. The overlay then stays off until the next reset, and the whole code space reads from user flash.

Top module: `boot_map_ctrl`

## Requirements
- R1: With a boot status value of zero and force_boot low, start_pc becomes 0x0000 and entered_boot is 0.
- R2: With a nonzero boot status value, start_pc becomes {boot_vec, 8'h00} and entered_boot is 1.
- R3: force_boot high at release has the same effect as a nonzero status value, whatever the status is.
- R4: The inputs are sampled only on the first rising clock edge with rst_n high. Later changes to boot_stat, boot_vec or force_boot do not alter start_pc or entered_boot until the next reset.
- R5: After reset the overlay is enabled. boot_sel is 1 exactly when fetch_addr lies in 0xFC00 to 0xFFFF. It does not depend on the clock.
- R6: An ovl_wr strobe with ovl_keep = 0 disables the overlay from the next clock edge onward. An ovl_wr strobe with ovl_keep = 1 never enables it again. Only a reset enables it again.
- R7: boot_addr always equals fetch_addr[9:0], and user_addr always equals fetch_addr.
- R8: The default vector byte 0xFC with a nonzero status gives the entry point 0xFC00.
- R9: While rst_n is low, start_pc is 0x0000, entered_boot is 0 and the overlay is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| boot_stat | input | 8 | Stored boot status value |
| boot_vec | input | 8 | Stored boot vector high byte |
| force_boot | input | 1 | Hardware request to enter boot code |
| ovl_wr | input | 1 | Overlay control write strobe |
| ovl_keep | input | 1 | Write data bit 0; a 0 disables the overlay |
| fetch_addr | input | 16 | Program fetch address from the core |
| start_pc | output | 16 | Start address held for the core |
| entered_boot | output | 1 | 1 when the core entered through the vector |
| boot_sel | output | 1 | Fetch is served by boot memory |
| boot_addr | output | 10 | Address into boot memory |
| user_addr | output | 16 | Address into user flash |

## Verification
start_pc and entered_boot are due at the first rising edge after rst_n is released. The bench releases reset on a falling edge and reads both results on the next falling edge. boot_sel, boot_addr and user_addr are combinational, so they are read in the same low phase in which fetch_addr was driven. An overlay write takes effect at the rising edge that samples it, so the bench reads boot_sel one falling edge after the strobe. After applying stimulus that should be ignored, the bench waits several cycles before checking.

// File: rtl/boot_map_ctrl.sv
module boot_map_ctrl #(
  parameter int ADDR_W  = 16,
  parameter int BOOT_AW = 10,
  parameter int STAT_W  = 8,
  parameter int VEC_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] boot_stat,
  input  logic [VEC_W-1:0]  boot_vec,
  input  logic              force_boot,
  input  logic              ovl_wr,
  input  logic              ovl_keep,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic [ADDR_W-1:0] start_pc,
  output logic              entered_boot,
  output logic              boot_sel,
  output logic [BOOT_AW-1:0] boot_addr,
  output logic [ADDR_W-1:0] user_addr
);
  localparam int LOW_W = ADDR_W - VEC_W;

  logic taken;
  logic ovl_en;
  logic go_vec;

  assign go_vec = force_boot || (boot_stat != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taken        <= 1'b0;
      start_pc     <= '0;
      entered_boot <= 1'b0;
    end else if (!taken) begin
      taken        <= 1'b1;
      entered_boot <= go_vec;
      start_pc     <= go_vec ? {boot_vec, {LOW_W{1'b0}}} : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 ovl_en <= 1'b1;
    else if (ovl_wr && !ovl_keep) ovl_en <= 1'b0;
  end

  assign boot_sel  = ovl_en && (&fetch_addr[ADDR_W-1:BOOT_AW]);
  assign boot_addr = fetch_addr[BOOT_AW-1:0];
  assign user_addr = fetch_addr;
endmodule

module boot_map_ctrl_chk #(
  parameter int ADDR_W  = 16,
  parameter int BOOT_AW = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              taken,
  input logic              ovl_en,
  input logic              ovl_wr,
  input logic              ovl_keep,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic [ADDR_W-1:0] start_pc,
  input logic              entered_boot,
  input logic              boot_sel
);
  // R5
  sel_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    boot_sel |-> (&fetch_addr[ADDR_W-1:BOOT_AW]));

  // R6
  ovl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovl_wr && !ovl_keep) |=> !ovl_en);

  // R6
  ovl_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ovl_en |=> !ovl_en);

  // R4
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    taken |=> ($stable(start_pc) && $stable(entered_boot)));

  // R1
  user_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && !entered_boot) |-> (start_pc == '0));
endmodule

bind boot_map_ctrl boot_map_ctrl_chk #(.ADDR_W(ADDR_W), .BOOT_AW(BOOT_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .taken(taken), .ovl_en(ovl_en),
  .ovl_wr(ovl_wr), .ovl_keep(ovl_keep), .fetch_addr(fetch_addr),
  .start_pc(start_pc), .entered_boot(entered_boot), .boot_sel(boot_sel)
);

// File: tb/test_boot_map_ctrl.sv
module test_boot_map_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] boot_stat = 8'h00;
  logic [7:0] boot_vec = 8'hFC;
  logic force_boot = 1'b0;
  logic ovl_wr = 1'b0;
  logic ovl_keep = 1'b1;
  logic [15:0] fetch_addr = 16'h0000;
  logic [15:0] start_pc;
  logic entered_boot;
  logic boot_sel;
  logic [9:0] boot_addr;
  logic [15:0] user_addr;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  boot_map_ctrl i_boot_map_ctrl (
    .clk(clk), .rst_n(rst_n), .boot_stat(boot_stat), .boot_vec(boot_vec),
    .force_boot(force_boot), .ovl_wr(ovl_wr), .ovl_keep(ovl_keep),
    .fetch_addr(fetch_addr), .start_pc(start_pc), .entered_boot(entered_boot),
    .boot_sel(boot_sel), .boot_addr(boot_addr), .user_addr(user_addr)
  );

  // stat, vec, force, expected pc, expected entered flag
  localparam logic [33:0] START_TV [6] = '{
    {8'h00, 8'hFC, 1'b0, 16'h0000, 1'b0},
    {8'h00, 8'h12, 1'b0, 16'h0000, 1'b0},
    {8'h01, 8'hFC, 1'b0, 16'hFC00, 1'b1},
    {8'h80, 8'h3A, 1'b0, 16'h3A00, 1'b1},
    {8'h00, 8'h55, 1'b1, 16'h5500, 1'b1},
    {8'hFF, 8'h00, 1'b1, 16'h0000, 1'b1}
  };

  // address, expected boot_sel with overlay enabled
  localparam logic [16:0] WIN_TV [6] = '{
    {16'hFBFF, 1'b0}, {16'hFC00, 1'b1}, {16'hFFFF, 1'b1},
    {16'h0000, 1'b0}, {16'hFE37, 1'b1}, {16'h7C00, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [7:0] s, input logic [7:0] v, input logic f);
    @(negedge clk);
    rst_n = 1'b0;
    boot_stat = s; boot_vec = v; force_boot = f;
    ovl_wr = 1'b0; ovl_keep = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    // R9 reset state
    boot_stat = 8'h01; boot_vec = 8'hAB; fetch_addr = 16'hFC10;
    repeat (2) @(negedge clk);
    chk("R9 pc", 32'(start_pc), 32'h0000);
    chk("R9 entered", 32'(entered_boot), 32'd0);
    chk("R9 overlay", 32'(boot_sel), 32'd1);

    for (int i = 0; i < 6; i++) begin
      do_reset(START_TV[i][33:26], START_TV[i][25:18], START_TV[i][17]);
      if (START_TV[i][17]) begin
        chk("R3 pc", 32'(start_pc), 32'(START_TV[i][16:1]));
        chk("R3 entered", 32'(entered_boot), 32'(START_TV[i][0]));
      end else if (START_TV[i][0]) begin
        chk(START_TV[i][25:18] == 8'hFC ? "R8 pc" : "R2 pc", 32'(start_pc), 32'(START_TV[i][16:1]));
        chk("R2 entered", 32'(entered_boot), 32'd1);
      end else begin
        chk("R1 pc", 32'(start_pc), 32'h0000);
        chk("R1 entered", 32'(entered_boot), 32'd0);
      end
    end

    // R4: late input changes are ignored
    do_reset(8'h02, 8'h40, 1'b0);
    boot_stat = 8'h00; boot_vec = 8'h99; force_boot = 1'b1;
    repeat (3) @(negedge clk);
    chk("R4 pc", 32'(start_pc), 32'h4000);
    chk("R4 entered", 32'(entered_boot), 32'd1);
    force_boot = 1'b0;
    repeat (2) @(negedge clk);
    chk("R4 entered hold", 32'(entered_boot), 32'd1);

    // R5 / R7 window decode
    for (int i = 0; i < 6; i++) begin
      fetch_addr = WIN_TV[i][16:1];
      #1;
      chk("R5 sel", 32'(boot_sel), 32'(WIN_TV[i][0]));
      chk("R7 boot addr", 32'(boot_addr), 32'(WIN_TV[i][10:1]));
      chk("R7 user addr", 32'(user_addr), 32'(WIN_TV[i][16:1]));
    end

    // R6 overlay control
    fetch_addr = 16'hFFFF;
    @(negedge clk); ovl_wr = 1'b1; ovl_keep = 1'b1;
    @(negedge clk); ovl_wr = 1'b0;
    chk("R6 keep write", 32'(boot_sel), 32'd1);
    ovl_wr = 1'b1; ovl_keep = 1'b0;
    #1;
    chk("R6 before edge", 32'(boot_sel), 32'd1);
    @(negedge clk); ovl_wr = 1'b0; ovl_keep = 1'b1;
    chk("R6 cleared", 32'(boot_sel), 32'd0);
    chk("R6 user addr", 32'(user_addr), 32'hFFFF);
    ovl_wr = 1'b1;
    @(negedge clk); ovl_wr = 1'b0;
    repeat (2) @(negedge clk);
    chk("R6 sticky", 32'(boot_sel), 32'd0);
    fetch_addr = 16'hFC00; #1;
    chk("R6 sticky low edge", 32'(boot_sel), 32'd0);

    // R5 re-enabled by reset
    do_reset(8'h00, 8'hFC, 1'b0);
    chk("R5 after reset", 32'(boot_sel), 32'd1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule